// File: doc/BRIEF.md
# SDRAM Single-Burst Access Sequencer

This block sits between a client and an SDRAM that has already been initialized and had its mode programmed. It takes one request at a time through a ready/valid handshake. A request carries direction, a 2-bit bank, row, column, the write words for a whole burst, and a per-beat byte mask. For each request the block opens the row, waits the row-to-column delay, and issues one burst read or burst write without auto-precharge. It then closes the bank with a precharge and waits the precharge recovery time before it accepts the next request.

The burst length code and CAS latency come from configuration inputs that mirror what was programmed into the device. The block samples both when it accepts a request. The data mask follows the device's rules. During a write, the mask acts in the same cycle as the data word. During a read, it must lead the data word by two cycles. The sequencer places each beat's mask accordingly. It returns every read beat with a one-cycle valid strobe, and masked bytes come back as zero because the device leaves them undriven.

Top module: `sdram_burst_seq`

## Requirements
- R1: While reset is held and afterwards until a request arrives, req_ready is 1, the command pins show deselect ({cs_n,ras_n,cas_n,we_n} = 1111), sd_dq_oe is 0 and rd_valid is 0.
- R2: A request is taken in a cycle where req_valid and req_ready are both 1. req_ready is then 0 from the next cycle until the precharge wait has ended.
- R3: In the cycle after acceptance the block drives an activate command (0011), with the row on sd_addr and the bank on sd_ba.
- R4: The read or write command comes exactly T_RCD cycles after the activate. The cycles in between, and every busy cycle that carries no other command, show NOP (0111).
- R5: A read command is 0101, with the column on the low sd_addr bits and all higher bits, A10 included, at 0, and the bank on sd_ba.
- R6: A write command is 0100, with the column placed as for a read. Beat i (i = 0 in the command cycle) drives req_wdata[i*DQ_W +: DQ_W] on sd_dq_o.
- R7: The burst length is 2^code for cfg_bl_code = 0..3, which gives 1, 2, 4 or 8. During a write, sd_dq_oe is 1 for exactly that many consecutive cycles.
- R8: During write beat i, sd_dqm equals req_mask[i*DM_W +: DM_W] in the same cycle. Mask bit j covers byte j, which is bits [8j+7:8j]. Outside any mask window sd_dqm is 0.
- R9: The CAS latency CL is 2 when cfg_cl3 is 0 and 3 when it is 1. Read beat i is sampled from sd_dq_i in cycle t+CL+i, where t is the read command cycle. rd_valid is 1 in cycle t+CL+i+1 with that word, for exactly burst-length cycles.
- R10: For read beat i, sd_dqm carries the beat's mask in cycle t+CL-2+i. A byte whose mask bit is set returns as zero in rd_data.
- R11: A precharge (0010) with A10 low and the accessed bank follows in the cycle after the last write beat, or in cycle t+CL+BL for a read. req_ready returns T_RP cycles after the precharge.
- R12: A request presented while req_ready is 0 is not accepted and changes no SDRAM pin. Only one request is ever in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bl_code | input | 2 | Burst length code, length = 2^code |
| cfg_cl3 | input | 1 | CAS latency select: 0 = 2, 1 = 3 |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_bank | input | 2 | Bank select |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Starting column |
| req_wdata | input | 8*DQ_W | Write words, beat 0 in the low bits |
| req_mask | input | 8*DQ_W/8 | Byte masks per beat, beat 0 in the low bits |
| rd_valid | output | 1 | Read word valid strobe |
| rd_data | output | DQ_W | Captured read word, masked bytes zero |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | ROW_W | Multiplexed row/column address |
| sd_dqm | output | DQ_W/8 | Byte data mask |
| sd_dq_o | output | DQ_W | Write data toward the device |
| sd_dq_oe | output | 1 | Write data output enable |
| sd_dq_i | input | DQ_W | Read data from the device |

## Verification
A corrupted phase counter moves the column command, the precharge or the end of busy by whole cycles. The per-cycle comparison of command pins and req_ready exposes this in the first cycle the edge lands in the wrong place. A wrong latency or mask offset shows at the latest when the first read beat is due: rd_valid arrives early or late, a sampled word differs from the bench's cycle-keyed pattern, or a byte that should be zero is not. A bad beat index on writes shows on sd_dq_o or sd_dqm in that beat's own cycle. A request accepted while busy shows up as a second activate or a changed address before the precharge recovery ends.

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq #(
  parameter int ROW_W = 12,
  parameter int COL_W = 9,
  parameter int DQ_W  = 16,
  parameter int T_RCD = 2,
  parameter int T_RP  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            cfg_bl_code,
  input  logic                  cfg_cl3,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [1:0]            req_bank,
  input  logic [ROW_W-1:0]      req_row,
  input  logic [COL_W-1:0]      req_col,
  input  logic [8*DQ_W-1:0]     req_wdata,
  input  logic [DQ_W-1:0]       req_mask,
  output logic                  rd_valid,
  output logic [DQ_W-1:0]       rd_data,
  output logic                  sd_cs_n,
  output logic                  sd_ras_n,
  output logic                  sd_cas_n,
  output logic                  sd_we_n,
  output logic [1:0]            sd_ba,
  output logic [ROW_W-1:0]      sd_addr,
  output logic [DQ_W/8-1:0]     sd_dqm,
  output logic [DQ_W-1:0]       sd_dq_o,
  output logic                  sd_dq_oe,
  input  logic [DQ_W-1:0]       sd_dq_i
);
  localparam int DM_W = DQ_W / 8;
  localparam int CW   = $clog2(T_RCD + T_RP + 16);
  localparam logic [3:0] C_DESEL = 4'b1111, C_NOP = 4'b0111, C_ACT = 4'b0011,
                         C_RD = 4'b0101, C_WR = 4'b0100, C_PRE = 4'b0010;

  typedef enum logic [2:0] {S_IDLE, S_ACT, S_RCD, S_XFER, S_PRE, S_RP} st_t;

  st_t                 st;
  logic [CW-1:0]       cnt;
  logic                q_wr, q_cl3;
  logic [1:0]          q_bank, q_blc;
  logic [ROW_W-1:0]    q_row;
  logic [COL_W-1:0]    q_col;
  logic [8*DQ_W-1:0]   q_data;
  logic [DQ_W-1:0]     q_mask;
  logic [3:0]          cmd;

  wire [CW-1:0] cl    = q_cl3 ? CW'(3) : CW'(2);
  wire [CW-1:0] bl_m1 = CW'((4'd1 << q_blc) - 4'd1);
  wire [CW-1:0] last  = q_wr ? bl_m1 : cl + bl_m1;
  wire [CW-1:0] ri    = cnt - CW'(q_cl3);
  wire          rwin  = !q_wr && (cnt >= CW'(q_cl3)) && (ri <= bl_m1);
  wire          cap   = (st == S_XFER) && !q_wr && (cnt >= cl);
  wire [2:0]    wbeat = cnt[2:0];
  wire [2:0]    rbeat = ri[2:0];
  wire [2:0]    cbeat = 3'(cnt - cl);

  logic [DM_W-1:0] cap_m;
  logic [DQ_W-1:0] cap_w;

  assign req_ready = (st == S_IDLE);
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_ba   = q_bank;
  assign sd_dq_o = q_data[wbeat*DQ_W +: DQ_W];

  always_comb begin
    cmd      = C_NOP;
    sd_addr  = '0;
    sd_dqm   = '0;
    sd_dq_oe = 1'b0;
    case (st)
      S_IDLE: cmd = C_DESEL;
      S_ACT: begin
        cmd     = C_ACT;
        sd_addr = q_row;
      end
      S_XFER: begin
        if (cnt == '0) begin
          cmd     = q_wr ? C_WR : C_RD;
          sd_addr = ROW_W'(q_col);
        end
        if (q_wr) begin
          sd_dq_oe = 1'b1;
          sd_dqm   = q_mask[wbeat*DM_W +: DM_W];
        end else if (rwin) begin
          sd_dqm   = q_mask[rbeat*DM_W +: DM_W];
        end
      end
      S_PRE: cmd = C_PRE;
      default: cmd = C_NOP;
    endcase
  end

  always_comb begin
    cap_m = q_mask[cbeat*DM_W +: DM_W];
    for (int j = 0; j < DM_W; j++)
      cap_w[j*8 +: 8] = cap_m[j] ? 8'h00 : sd_dq_i[j*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0;
      q_wr <= 1'b0; q_cl3 <= 1'b0; q_bank <= '0; q_blc <= '0;
      q_row <= '0; q_col <= '0; q_data <= '0; q_mask <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          st <= S_ACT; cnt <= '0;
          q_wr <= req_write; q_cl3 <= cfg_cl3; q_blc <= cfg_bl_code;
          q_bank <= req_bank; q_row <= req_row; q_col <= req_col;
          q_data <= req_wdata; q_mask <= req_mask;
        end
        S_ACT: begin
          st  <= (T_RCD > 1) ? S_RCD : S_XFER;
          cnt <= '0;
        end
        S_RCD:
          if (cnt == CW'(T_RCD - 2)) begin st <= S_XFER; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        S_XFER:
          if (cnt == last) begin st <= S_PRE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        S_PRE: begin
          st  <= (T_RP > 1) ? S_RP : S_IDLE;
          cnt <= '0;
        end
        default:
          if (cnt == CW'(T_RP - 2)) begin st <= S_IDLE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cap;
      if (cap) rd_data <= cap_w;
    end
  end

  logic [CW-1:0] since_act, since_pre;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= '1;
      since_pre <= '1;
    end else begin
      if (cmd == C_ACT) since_act <= CW'(1);
      else if (since_act != '1) since_act <= since_act + 1'b1;
      if (cmd == C_PRE) since_pre <= CW'(1);
      else if (since_pre != '1) since_pre <= since_pre + 1'b1;
    end
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd == C_ACT && !req_ready));
  p_trcd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_RD || cmd == C_WR) |-> (since_act == CW'(T_RCD)));
  p_wr_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_WR) |-> sd_dq_oe);
  p_rd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !sd_dq_oe);
  p_trp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT) |-> (since_pre >= CW'(T_RP)));
endmodule

// File: tb/test_sdram_burst_seq.sv
module test_sdram_burst_seq;
  localparam int CLK_P = 10;
  localparam int ROW_W = 12, COL_W = 9, DQ_W = 16, TRCD = 3, TRP = 2;
  localparam logic [3:0] DESEL = 4'b1111, NOP = 4'b0111, ACT = 4'b0011,
                         RD = 4'b0101, WR = 4'b0100, PRE = 4'b0010;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_bl_code = '0;
  logic cfg_cl3 = 1'b0, req_valid = 1'b0, req_write = 1'b0, req_ready;
  logic [1:0] req_bank = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [8*DQ_W-1:0] req_wdata = '0;
  logic [DQ_W-1:0] req_mask = '0;
  logic rd_valid, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [DQ_W-1:0] rd_data, sd_dq_o, sd_dq_i = '0;
  logic [1:0] sd_ba, sd_dqm;
  logic [ROW_W-1:0] sd_addr;

  sdram_burst_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W), .T_RCD(TRCD), .T_RP(TRP)) i_sdram_burst_seq (
    .clk(clk), .rst_n(rst_n), .cfg_bl_code(cfg_bl_code), .cfg_cl3(cfg_cl3),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_wdata(req_wdata), .req_mask(req_mask), .rd_valid(rd_valid), .rd_data(rd_data),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_o(sd_dq_o),
    .sd_dq_oe(sd_dq_oe), .sd_dq_i(sd_dq_i));

  always #(CLK_P/2) clk = ~clk;

  int cyc = 0, n_chk = 0, n_fail = 0;
  bit chk_en = 0, done = 0;
  always @(posedge clk) cyc++;

  logic [3:0] e_cmd [int];
  string e_tag [int], e_rtag [int];
  logic [ROW_W-1:0] e_addr [int];
  logic [1:0] e_ba [int], e_dqm [int];
  bit e_busy [int], e_oe [int], e_rv [int];
  logic [DQ_W-1:0] e_dq [int], e_rd [int];

  function automatic logic [DQ_W-1:0] pat(int k);
    return DQ_W'(k * 40503) ^ 16'hA5C3;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] a, logic [31:0] e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s cycle %0d act=%h exp=%h", tag, what, cyc, a, e);
    end
  endtask

  always @(negedge clk) if (chk_en) begin
    automatic bit busy = e_busy.exists(cyc);
    automatic logic [3:0] xc = e_cmd.exists(cyc) ? e_cmd[cyc] : (busy ? NOP : DESEL);
    automatic string tg = e_tag.exists(cyc) ? e_tag[cyc] : (busy ? "R4" : "R1");
    automatic logic [1:0] xm = e_dqm.exists(cyc) ? e_dqm[cyc] : 2'b00;
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == xc, tg, "cmd",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, xc);
    if (xc == ACT || xc == RD || xc == WR) begin
      chk(sd_addr == e_addr[cyc], tg, "addr", sd_addr, e_addr[cyc]);
      chk(sd_ba == e_ba[cyc], tg, "bank", sd_ba, e_ba[cyc]);
    end
    if (xc == PRE) begin
      chk(sd_addr[10] == 1'b0, "R11", "a10", sd_addr[10], 0);
      chk(sd_ba == e_ba[cyc], "R11", "bank", sd_ba, e_ba[cyc]);
    end
    chk(sd_dq_oe == e_oe.exists(cyc), "R7", "oe", sd_dq_oe, e_oe.exists(cyc));
    if (e_oe.exists(cyc)) chk(sd_dq_o == e_dq[cyc], "R6", "wdata", sd_dq_o, e_dq[cyc]);
    chk(sd_dqm == xm, (e_oe.exists(cyc) || xm == 0) ? "R8" : "R10", "dqm", sd_dqm, xm);
    chk(req_ready == !busy, "R2", "ready", req_ready, !busy);
    chk(rd_valid == e_rv.exists(cyc), "R9", "rd_valid", rd_valid, e_rv.exists(cyc));
    if (e_rv.exists(cyc)) chk(rd_data == e_rd[cyc], e_rtag[cyc], "rd_data", rd_data, e_rd[cyc]);
    if (req_valid && busy) chk(!req_ready, "R12", "busy_ready", req_ready, 0);
    sd_dq_i = pat(cyc);
  end

  task automatic do_req(bit wr, logic [1:0] bank, logic [ROW_W-1:0] row, logic [COL_W-1:0] col,
                        logic [1:0] blc, bit cl3, logic [8*DQ_W-1:0] wd, logic [DQ_W-1:0] mk, bit spam);
    int k = cyc;
    int bl = 1 << blc;
    int cl = cl3 ? 3 : 2;
    int t = k + 1 + TRCD;
    int p;
    req_write = wr; req_bank = bank; req_row = row; req_col = col;
    req_wdata = wd; req_mask = mk; cfg_bl_code = blc; cfg_cl3 = cl3; req_valid = 1'b1;
    e_cmd[k+1] = ACT; e_addr[k+1] = row; e_ba[k+1] = bank; e_tag[k+1] = "R3";
    e_cmd[t] = wr ? WR : RD; e_addr[t] = ROW_W'(col); e_ba[t] = bank; e_tag[t] = wr ? "R6" : "R5";
    if (wr) begin
      for (int i = 0; i < bl; i++) begin
        e_oe[t+i] = 1; e_dq[t+i] = wd[i*DQ_W +: DQ_W]; e_dqm[t+i] = mk[i*2 +: 2];
      end
      p = t + bl;
    end else begin
      for (int i = 0; i < bl; i++) begin
        automatic logic [DQ_W-1:0] w = pat(t + cl + i);
        automatic logic [1:0] m = mk[i*2 +: 2];
        if (m[0]) w[7:0] = 8'h00;
        if (m[1]) w[15:8] = 8'h00;
        e_dqm[t+cl-2+i] = m;
        e_rv[t+cl+i+1] = 1; e_rd[t+cl+i+1] = w; e_rtag[t+cl+i+1] = (m != 0) ? "R10" : "R9";
      end
      p = t + cl + bl;
    end
    e_cmd[p] = PRE; e_ba[p] = bank; e_tag[p] = "R11";
    for (int c = k + 1; c < p + TRP; c++) e_busy[c] = 1;
    @(negedge clk);
    req_valid = 1'b0;
    if (spam) begin
      @(negedge clk);
      req_valid = 1'b1; req_row = ~row; req_bank = ~bank; req_write = ~wr; req_col = ~col;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
    end
    while (cyc < p + TRP) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset_ready", req_ready, 1);
    chk(sd_cs_n == 1'b1, "R1", "reset_cs", sd_cs_n, 1);
    chk(sd_dq_oe == 1'b0, "R1", "reset_oe", sd_dq_oe, 0);
    chk(rd_valid == 1'b0, "R1", "reset_rv", rd_valid, 0);
    rst_n = 1'b1;
    chk_en = 1;
    repeat (2) @(negedge clk);
    do_req(1, 2'd1, 12'h123, 9'h045, 2'd2, 0, 128'h0000_0000_0000_0000_4444_3333_2222_1111, 16'h0024, 0);
    do_req(0, 2'd2, 12'hABC, 9'h1FF, 2'd3, 0, '0, 16'h9C21, 0);
    do_req(0, 2'd3, 12'h7FF, 9'h001, 2'd0, 1, '0, 16'h0002, 0);
    do_req(1, 2'd0, 12'hFFF, 9'h100, 2'd3, 1,
           128'h8888_7777_6666_5555_4444_3333_2222_1111, 16'hC003, 1);
    do_req(0, 2'd1, 12'h055, 9'h0AA, 2'd1, 1, '0, 16'h0000, 1);
    do_req(1, 2'd3, 12'h800, 9'h0F0, 2'd0, 0, 128'hBEEF, 16'h0001, 0);
    repeat (3) @(negedge clk);
    do_req(0, 2'd0, 12'h321, 9'h010, 2'd2, 0, '0, 16'h0300, 0);
    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule